// File: doc/BRIEF.md
# SIMD Lane Array with Per-Lane Inhibit

This block is a row of identical arithmetic lanes driven by one sequencer. The sequencer issues each step to all lanes in the same cycle. Every lane owns one operand bank, so a whole row of elements, one word per lane, is read in a single cycle. A run adds two stored vectors of a given length element by element and writes the sums to a third stored vector. It walks the vectors one block of LANES elements at a time.

Each lane computes an inhibit decision on every block. A lane stays idle if its element index lies beyond the vector length, or if the selected per-element condition fails. An idle lane keeps its result word as it was. The array still moves in lockstep, so the run time depends only on the length. Before a run, software fills the operand and result words through a load port. Afterwards it reads the results through a read port. A single-cycle `done` pulse marks the end of a run.

Top module: `simd_lane_array`

## Requirements
- R1: For every element i below the effective length whose lane is enabled, result word C[i] becomes (A[i] + B[i]) modulo 2^WIDTH.
- R2: While no run is in progress, no result word changes except through the load port.
- R3: Element i is held in lane i mod LANES at row i / LANES. A run processes ceil(len/LANES) blocks in ascending row order.
- R4: In the final partial block, the lanes whose element index is at or beyond the length leave their result word unchanged.
- R5: `cond_sel` is latched at start. 0 enables every element, 1 enables elements with A[i] > 0 (signed), 2 enables elements with B[i] != 0, and 3 enables elements with A[i] > B[i] (signed).
- R6: An element whose condition is false keeps its previous result word.
- R7: `done` is high for exactly one cycle per run.
- R8: With start sampled at clock edge k and length n > 0, `done` goes high after edge k + 2*ceil(n/LANES), independent of the condition outcomes.
- R9: A start with length 0 writes nothing and raises `done` after the sampling edge itself.
- R10: A length above LANES*ROWS is clamped to LANES*ROWS.
- R11: A start pulse received during a run is ignored. The run's length, condition and timing do not change.
- R12: After reset, `done` is low and no run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| vec_len | input | LEN_W | Number of elements to process |
| cond_sel | input | 2 | Per-element condition code (R5) |
| done | output | 1 | One-cycle end-of-run pulse |
| ld_we | input | 1 | Load-port write strobe |
| ld_sel | input | 2 | Load target: 0 = A, 1 = B, 2 = C, 3 = none |
| ld_addr | input | IDX_W | Element index for the load |
| ld_data | input | WIDTH | Load word |
| rd_addr | input | IDX_W | Element index of the result word read |
| rd_data | output | WIDTH | Result word C[rd_addr] (combinational) |

## Verification
The bench fills every result word with a marker before each run. A design that lets a tail lane or a failed-condition lane write would overwrite markers past the length or under a false condition. Run time is measured for each pattern, so a sequencer that skips idle lanes or adds a block for an exact multiple of LANES gives a cycle count that differs from the expected one. Zero length, an over-capacity length and a second start during a run are each driven directly. A wrong design would write nothing or hang on zero length, run past the storage, or restart with the intruding length.

// File: rtl/sla_pkg.sv
package sla_pkg;
   typedef enum logic [1:0] {
      COND_ALWAYS = 2'd0,
      COND_A_POS  = 2'd1,
      COND_B_NZ   = 2'd2,
      COND_A_GT_B = 2'd3
   } cond_e;

   typedef enum logic [1:0] {
      LD_A    = 2'd0,
      LD_B    = 2'd1,
      LD_C    = 2'd2,
      LD_NONE = 2'd3
   } ld_tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_EXEC  = 2'd2
   } seq_st_e;
endpackage

// File: rtl/sla_bank.sv
module sla_bank #(
   parameter int WIDTH = 16,
   parameter int ROWS  = 8,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic                 clk,
   input  logic                 ld_we,
   input  sla_pkg::ld_tgt_e     ld_sel,
   input  logic [ROW_W-1:0]     ld_row,
   input  logic [WIDTH-1:0]     ld_data,
   input  logic                 fetch,
   input  logic [ROW_W-1:0]     op_row,
   output logic [WIDTH-1:0]     a_q,
   output logic [WIDTH-1:0]     b_q,
   input  logic                 wr,
   input  logic [WIDTH-1:0]     wr_data,
   input  logic [ROW_W-1:0]     prd_row,
   output logic [WIDTH-1:0]     prd_data
);
   logic [WIDTH-1:0] mem_a [ROWS];
   logic [WIDTH-1:0] mem_b [ROWS];
   logic [WIDTH-1:0] mem_c [ROWS];

   always_ff @(posedge clk) begin
      if (ld_we && ld_sel == sla_pkg::LD_A) mem_a[ld_row] <= ld_data;
      if (ld_we && ld_sel == sla_pkg::LD_B) mem_b[ld_row] <= ld_data;
      if (wr)
         mem_c[op_row] <= wr_data;
      else if (ld_we && ld_sel == sla_pkg::LD_C)
         mem_c[ld_row] <= ld_data;
      if (fetch) begin
         a_q <= mem_a[op_row];
         b_q <= mem_b[op_row];
      end
   end

   assign prd_data = mem_c[prd_row];
endmodule

// File: rtl/sla_lane.sv
module sla_lane #(
   parameter int WIDTH   = 16,
   parameter int LEN_W   = 6,
   parameter int LANE_ID = 0
) (
   input  logic               exec,
   input  sla_pkg::cond_e     cond,
   input  logic [LEN_W-1:0]   base,
   input  logic [LEN_W-1:0]   limit,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic               wr,
   output logic [WIDTH-1:0]   sum
);
   logic in_range;
   logic hit;

   assign in_range = (32'(base) + LANE_ID) < 32'(limit);

   always_comb begin
      unique case (cond)
         sla_pkg::COND_ALWAYS: hit = 1'b1;
         sla_pkg::COND_A_POS:  hit = $signed(a) > 0;
         sla_pkg::COND_B_NZ:   hit = b != '0;
         sla_pkg::COND_A_GT_B: hit = $signed(a) > $signed(b);
         default:              hit = 1'b0;
      endcase
   end

   assign wr  = exec & in_range & hit;
   assign sum = a + b;
endmodule

// File: rtl/sla_seq.sv
module sla_seq #(
   parameter int LANES = 4,
   parameter int ROWS  = 8,
   localparam int CAP   = LANES * ROWS,
   localparam int LEN_W = $clog2(CAP + 1),
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LEN_W-1:0]   len,
   input  sla_pkg::cond_e     cond_in,
   output logic               fetch,
   output logic               exec,
   output logic               running,
   output logic [ROW_W-1:0]   row,
   output logic [LEN_W-1:0]   base,
   output logic [LEN_W-1:0]   limit,
   output sla_pkg::cond_e     cond_q,
   output logic               done
);
   sla_pkg::seq_st_e  st_q;
   logic [ROW_W-1:0]  row_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  len_eff;
   logic              last_blk;

   assign len_eff  = (32'(len) > CAP) ? LEN_W'(CAP) : len;
   assign last_blk = (32'(row_q) + 32'd1) * LANES >= 32'(len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= sla_pkg::ST_IDLE;
         row_q  <= '0;
         len_q  <= '0;
         cond_q <= sla_pkg::COND_ALWAYS;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            sla_pkg::ST_IDLE:
               if (start) begin
                  if (len_eff == '0) begin
                     done <= 1'b1;
                  end else begin
                     len_q  <= len_eff;
                     cond_q <= cond_in;
                     row_q  <= '0;
                     st_q   <= sla_pkg::ST_FETCH;
                  end
               end
            sla_pkg::ST_FETCH:
               st_q <= sla_pkg::ST_EXEC;
            sla_pkg::ST_EXEC:
               if (last_blk) begin
                  st_q <= sla_pkg::ST_IDLE;
                  done <= 1'b1;
               end else begin
                  row_q <= row_q + 1'b1;
                  st_q  <= sla_pkg::ST_FETCH;
               end
            default:
               st_q <= sla_pkg::ST_IDLE;
         endcase
      end
   end

   assign fetch   = st_q == sla_pkg::ST_FETCH;
   assign exec    = st_q == sla_pkg::ST_EXEC;
   assign running = st_q != sla_pkg::ST_IDLE;
   assign row     = row_q;
   assign base    = LEN_W'(32'(row_q) * LANES);
   assign limit   = len_q;

   // R7: the end-of-run strobe never lasts two cycles
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: every executed block holds at least one element inside the length
   a_r3_block_in_len: assert property (@(posedge clk) disable iff (!rst_n)
      exec |-> (32'(row_q) * LANES < 32'(len_q)));

   // R11: a start during a run leaves the latched length alone
   a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start) |=> (len_q == $past(len_q)));
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array #(
   parameter int WIDTH = 16,
   parameter int LANES = 4,
   parameter int ROWS  = 8,
   localparam int CAP   = LANES * ROWS,
   localparam int LEN_W = $clog2(CAP + 1),
   localparam int IDX_W = $clog2(CAP),
   localparam int SH    = $clog2(LANES),
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LEN_W-1:0]   vec_len,
   input  logic [1:0]         cond_sel,
   output logic               done,
   input  logic               ld_we,
   input  logic [1:0]         ld_sel,
   input  logic [IDX_W-1:0]   ld_addr,
   input  logic [WIDTH-1:0]   ld_data,
   input  logic [IDX_W-1:0]   rd_addr,
   output logic [WIDTH-1:0]   rd_data
);
   initial begin
      assert (LANES >= 2 && (LANES & (LANES - 1)) == 0)
         else $error("LANES must be a power of two, at least 2");
      assert (ROWS >= 2 && (ROWS & (ROWS - 1)) == 0)
         else $error("ROWS must be a power of two, at least 2");
      assert (WIDTH >= 2) else $error("WIDTH too small");
   end

   logic               fetch, exec, running;
   logic [ROW_W-1:0]   row;
   logic [LEN_W-1:0]   base, limit;
   sla_pkg::cond_e     cond_q;
   logic [LANES-1:0]   wr_vec;
   logic [WIDTH-1:0]   op_a  [LANES];
   logic [WIDTH-1:0]   op_b  [LANES];
   logic [WIDTH-1:0]   sum   [LANES];
   logic [WIDTH-1:0]   c_rd  [LANES];

   sla_seq #(.LANES(LANES), .ROWS(ROWS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .len     (vec_len),
      .cond_in (sla_pkg::cond_e'(cond_sel)),
      .fetch   (fetch),
      .exec    (exec),
      .running (running),
      .row     (row),
      .base    (base),
      .limit   (limit),
      .cond_q  (cond_q),
      .done    (done)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic ld_hit;
      assign ld_hit = ld_we && (ld_addr[SH-1:0] == SH'(l));

      sla_bank #(.WIDTH(WIDTH), .ROWS(ROWS)) u_bank (
         .clk      (clk),
         .ld_we    (ld_hit),
         .ld_sel   (sla_pkg::ld_tgt_e'(ld_sel)),
         .ld_row   (ld_addr[IDX_W-1:SH]),
         .ld_data  (ld_data),
         .fetch    (fetch),
         .op_row   (row),
         .a_q      (op_a[l]),
         .b_q      (op_b[l]),
         .wr       (wr_vec[l]),
         .wr_data  (sum[l]),
         .prd_row  (rd_addr[IDX_W-1:SH]),
         .prd_data (c_rd[l])
      );

      sla_lane #(.WIDTH(WIDTH), .LEN_W(LEN_W), .LANE_ID(l)) u_lane (
         .exec  (exec),
         .cond  (cond_q),
         .base  (base),
         .limit (limit),
         .a     (op_a[l]),
         .b     (op_b[l]),
         .wr    (wr_vec[l]),
         .sum   (sum[l])
      );
   end

   assign rd_data = c_rd[rd_addr[SH-1:0]];

   // R2: lanes stay silent whenever the sequencer is idle
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (wr_vec == '0));

   // R4: a block never writes more lanes than elements remain
   a_r4_tail_count: assert property (@(posedge clk) disable iff (!rst_n)
      exec |-> ($countones(wr_vec) <= 32'(limit) - 32'(base)));
endmodule

// File: tb/simd_lane_array_bench.sv
module simd_lane_array_bench;
   localparam int WIDTH = 16;
   localparam int LANES = 4;
   localparam int ROWS  = 8;
   localparam int CAP   = LANES * ROWS;
   localparam int LEN_W = $clog2(CAP + 1);
   localparam int IDX_W = $clog2(CAP);
   localparam int NT    = 6;

   // table: length, condition code, data seed
   localparam int T_LEN  [NT] = '{32, 7, 13, 20, 29, 1};
   localparam int T_COND [NT] = '{0, 0, 1, 2, 3, 0};
   localparam int T_SEED [NT] = '{3, 11, 25, 40, 57, 71};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [LEN_W-1:0]   vec_len = '0;
   logic [1:0]         cond_sel = '0;
   logic               done;
   logic               ld_we = 1'b0;
   logic [1:0]         ld_sel = 2'd3;
   logic [IDX_W-1:0]   ld_addr = '0;
   logic [WIDTH-1:0]   ld_data = '0;
   logic [IDX_W-1:0]   rd_addr = '0;
   logic [WIDTH-1:0]   rd_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   simd_lane_array #(.WIDTH(WIDTH), .LANES(LANES), .ROWS(ROWS)) u_simd_lane_array (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
      .cond_sel(cond_sel), .done(done), .ld_we(ld_we), .ld_sel(ld_sel),
      .ld_addr(ld_addr), .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [WIDTH-1:0] gen_a(int s, int i);
      return WIDTH'((s * 977 + i * 4111) ^ (i * 53));
   endfunction
   function automatic logic [WIDTH-1:0] gen_b(int s, int i);
      return (i % 4 == 1) ? '0 : WIDTH'(s * 313 - i * 2903);
   endfunction
   function automatic logic [WIDTH-1:0] gen_c(int s, int i);
      return WIDTH'(16'hC0DE ^ (i * 7) ^ s);
   endfunction
   function automatic bit cond_ok(int c, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
      case (c)
         0: return 1'b1;
         1: return $signed(a) > 0;
         2: return b != '0;
         default: return $signed(a) > $signed(b);
      endcase
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load(int sel, int idx, logic [WIDTH-1:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_sel = 2'(sel); ld_addr = IDX_W'(idx); ld_data = d;
      @(posedge clk);
      @(negedge clk);
      ld_we = 1'b0; ld_sel = 2'd3;
   endtask

   task automatic fill(int s);
      for (int i = 0; i < CAP; i++) begin
         load(0, i, gen_a(s, i));
         load(1, i, gen_b(s, i));
         load(2, i, gen_c(s, i));
      end
   endtask

   task automatic run(int len, int c, bit inject, output int cyc, output bit pulse_ok);
      @(negedge clk);
      vec_len = LEN_W'(len); cond_sel = 2'(c); start = 1'b1;
      @(posedge clk);
      cyc = 1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 100) begin
         if (inject && cyc == 2) begin
            start = 1'b1; vec_len = LEN_W'(5); cond_sel = 2'd3;
         end
         @(posedge clk);
         cyc++;
         @(negedge clk);
         start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      pulse_ok = !done;
   endtask

   task automatic verify(int len, int c, int s, string req);
      int eff = (len > CAP) ? CAP : len;
      int bad = 0;
      for (int i = 0; i < CAP; i++) begin
         logic [WIDTH-1:0] a = gen_a(s, i);
         logic [WIDTH-1:0] b = gen_b(s, i);
         logic [WIDTH-1:0] exp;
         rd_addr = IDX_W'(i);
         #1;
         if (i < eff && cond_ok(c, a, b)) exp = a + b;
         else exp = gen_c(s, i);
         if (rd_data !== exp) begin
            bad++;
            check(1'b0, req, int'(rd_data), int'(exp));
         end
      end
      if (bad == 0) check(1'b1, req, 0, 0);
   endtask

   function automatic int exp_cycles(int len);
      int eff = (len > CAP) ? CAP : len;
      return (eff == 0) ? 1 : 2 * ((eff + LANES - 1) / LANES) + 1;
   endfunction

   initial begin
      int cyc;
      bit pok;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(done === 1'b0, "R12 done low in reset", int'(done), 0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(done === 1'b0, "R12 done low after reset", int'(done), 0);

      // table of patterns: R1 R3 R4 R5 R6 R8 R7
      for (int t = 0; t < NT; t++) begin
         fill(T_SEED[t]);
         run(T_LEN[t], T_COND[t], 1'b0, cyc, pok);
         check(cyc == exp_cycles(T_LEN[t]), "R8 cycle count", cyc, exp_cycles(T_LEN[t]));
         check(pok, "R7 done single cycle", int'(!pok), 0);
         verify(T_LEN[t], T_COND[t], T_SEED[t], "R1/R4/R5/R6 result words");
      end

      // R2: idle cycles with loads of A/B only leave C untouched
      fill(90);
      repeat (10) @(posedge clk);
      load(0, 3, 16'h1234);
      verify(0, 0, 90, "R2 idle no write");

      // R9: zero length
      run(0, 0, 1'b0, cyc, pok);
      check(cyc == 1, "R9 zero length done", cyc, 1);
      verify(0, 0, 90, "R9 zero length writes nothing");

      // R10: over-capacity length clamps
      fill(101);
      run(40, 0, 1'b0, cyc, pok);
      check(cyc == exp_cycles(CAP), "R10 clamped cycle count", cyc, exp_cycles(CAP));
      verify(40, 0, 101, "R10 clamped results");

      // R11: second start in mid-run ignored
      fill(117);
      run(8, 0, 1'b1, cyc, pok);
      check(cyc == exp_cycles(8), "R11 timing unchanged", cyc, exp_cycles(8));
      check(pok, "R11 R7 single done", int'(!pok), 0);
      verify(8, 0, 117, "R11 length unchanged");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule